// File: doc/BRIEF.md
# Command-Link Register Loader

This block unpacks one linked channel command into individual register writes. A command is a stream of 32-bit words offered with valid/ready: a header word comes first, then payload words packed with no addresses. Each set header bit that names a channel register takes one payload word. The words are matched to those bits starting at the least significant set bit and moving upward. The loader turns each payload word into a one-cycle write strobe that carries the register index and the data. When the whole list has been applied, it issues a one-cycle start pulse to the transfer engine.

Header bit 0 is a clear request. It holds the channel registers in clear (`clr_busy`) for a fixed number of cycles before any payload is applied. When the command carries a next-link address, that address is reported together with the start pulse, so that a fetcher can follow the chain. Bit 0 of the link word says whether the chain continues.

Top module: `cl_loader`

## Requirements
- R1: While reset is asserted, and after it is released, `wr_en`, `start`, `clr_busy` and `link_vld` are low. After release, the loader is idle with `s_ready` high, waiting for a header.
- R2: A payload word accepted on a valid/ready handshake appears in the following cycle as `wr_en`=1. `wr_data` equals the word, and `wr_idx` is the number of the header bit that the word belongs to.
- R3: Only these header bits name registers and consume a payload word: 2 through 12, 14, 19, 20, 29, 30 and 31. Bits 1, 13, 15–18 and 21–28 are ignored and consume nothing.
- R4: When header bit 0 is set, `clr_busy` is high for exactly CLR_CYC cycles, starting in the cycle after the header is accepted. During those cycles `s_ready` and `wr_en` stay low, and a word held valid then is accepted only after the clear ends. Bit 0 consumes no payload word.
- R5: `start` is a one-cycle pulse in the cycle after the last write strobe of a command. No write strobe is active in that cycle.
- R6: A header with no register bits raises `start` in the cycle right after the header is accepted. If the header also requests a clear, `start` rises in the cycle right after the clear ends.
- R7: `link_vld` is high with `start` exactly when the command loaded bit 30. In that case `link_go` equals bit 0 of that word. `link_addr` is {bit-31 word, or zero if that bit was absent; bit-30 word with bit 0 cleared}.
- R8: `s_ready` is low from the cycle after the last payload handshake up to and including the start cycle. A new header is accepted in the cycle after `start`.
- R9: Idle cycles in `s_valid` during the payload produce no write strobe, and no word is lost or repeated.
- R10: Within a command, write strobes come in strictly ascending `wr_idx` order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_valid | input | 1 | Command word valid |
| s_ready | output | 1 | Command word accepted when high with s_valid |
| s_data | input | 32 | Command word (header or payload) |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | Target register index (header bit number) |
| wr_data | output | 32 | Register write data |
| clr_busy | output | 1 | Channel register clear in progress |
| start | output | 1 | One-cycle transfer start pulse |
| link_vld | output | 1 | Next-link address reported this cycle |
| link_go | output | 1 | Chain continues (link enable bit) |
| link_addr | output | 64 | Next command address, bit 0 cleared |

## Verification
The hardest case to reach is a first payload word that arrives while a clear is still running. That word must be held off and then taken exactly once. The bench keeps that word valid throughout every clear window, then checks that the first strobe after the clear carries it. The bench also sweeps every single-bit header, the full mask and several hundred pseudo-random headers. It inserts valid gaps at rotating positions so that stalls land between words, including directly before the link words whose enable bit changes.

// File: rtl/cl_pkg.sv
package cl_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = $clog2(WORD_W);
  localparam int unsigned LADR_W = 2 * WORD_W;

  // header bits that own one payload word each
  localparam logic [WORD_W-1:0] LOAD_MASK = 32'hE018_5FFC;

  localparam int unsigned CLR_BIT     = 0;
  localparam int unsigned LINK_LO_BIT = 30;
  localparam int unsigned LINK_HI_BIT = 31;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_LOAD  = 2'd2,
    ST_FIRE  = 2'd3
  } ld_state_e;
endpackage

// File: rtl/cl_lsb_pick.sv
module cl_lsb_pick #(
  parameter int unsigned W = 32,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  rest_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o  = |vec_i;
  assign rest_o = vec_i & (vec_i - W'(1));
endmodule

// File: rtl/cl_clr_timer.sv
module cl_clr_timer #(
  parameter int unsigned CYC = 3,
  localparam int unsigned CW = (CYC > 1) ? $clog2(CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i | (run_i & (cnt_q != '0));
    cnt_d  = load_i ? CW'(CYC - 1) : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/cl_link_cap.sv
module cl_link_cap
  import cl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_acc_i,
  input  logic              word_acc_i,
  input  logic [IDX_W-1:0]  word_idx_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              seen_o,
  output logic              go_o,
  output logic [LADR_W-1:0] addr_o
);
  logic [WORD_W-1:0] lo_q, hi_q;
  logic              seen_q;
  logic              lo_hit, hi_hit;

  assign lo_hit = word_acc_i & (word_idx_i == IDX_W'(LINK_LO_BIT));
  assign hi_hit = word_acc_i & (word_idx_i == IDX_W'(LINK_HI_BIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      seen_q <= 1'b0;
    end else if (hdr_acc_i) begin
      lo_q   <= '0;
      seen_q <= 1'b0;
    end else if (lo_hit) begin
      lo_q   <= word_i;
      seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_q <= '0;
    else if (hdr_acc_i) hi_q <= '0;
    else if (hi_hit)    hi_q <= word_i;
  end

  assign seen_o = seen_q;
  assign go_o   = lo_q[0];
  assign addr_o = {hi_q, lo_q[WORD_W-1:1], 1'b0};
endmodule

// File: rtl/cl_loader.sv
module cl_loader
  import cl_pkg::*;
#(
  parameter int unsigned CLR_CYC     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [WORD_W-1:0] wr_data,
  output logic              clr_busy,
  output logic              start,
  output logic              link_vld,
  output logic              link_go,
  output logic [LADR_W-1:0] link_addr
);
  // ---------------- reset release synchronizer ----------------
  logic rst_int_n;

  generate
    if (SYNC_STAGES < 2) begin : g_sync1
      logic rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= 1'b0;
        else        rs_q <= 1'b1;
      end
      assign rst_int_n = rs_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_int_n = rs_q[SYNC_STAGES-1];
    end
  endgenerate

  // ---------------- state ----------------
  ld_state_e         state_q, state_d;
  logic [WORD_W-1:0] pend_q, pend_d;
  logic              pend_en;
  logic              wr_en_q;
  logic [IDX_W-1:0]  wr_idx_q;
  logic [WORD_W-1:0] wr_data_q;

  logic              pend_any;
  logic [IDX_W-1:0]  pend_idx;
  logic [WORD_W-1:0] pend_rest;
  logic [WORD_W-1:0] hdr_pend;
  logic              hdr_acc, word_acc;
  logic              clr_last;
  logic              link_seen, link_en_bit;

  cl_lsb_pick #(.W(WORD_W)) u_pick (
    .vec_i  (pend_q),
    .any_o  (pend_any),
    .idx_o  (pend_idx),
    .rest_o (pend_rest)
  );

  cl_clr_timer #(.CYC(CLR_CYC)) u_clr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (hdr_acc & s_data[CLR_BIT]),
    .run_i  (state_q == ST_CLEAR),
    .last_o (clr_last)
  );

  cl_link_cap u_link (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .hdr_acc_i  (hdr_acc),
    .word_acc_i (word_acc),
    .word_idx_i (pend_idx),
    .word_i     (s_data),
    .seen_o     (link_seen),
    .go_o       (link_en_bit),
    .addr_o     (link_addr)
  );

  // ---------------- handshake decode ----------------
  always_comb begin
    hdr_pend = s_data & LOAD_MASK;
    s_ready  = (state_q == ST_IDLE) | ((state_q == ST_LOAD) & pend_any);
    hdr_acc  = (state_q == ST_IDLE) & s_valid;
    word_acc = (state_q == ST_LOAD) & pend_any & s_valid;
  end

  // ---------------- next state ----------------
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (s_valid) begin
          if (s_data[CLR_BIT])      state_d = ST_CLEAR;
          else if (hdr_pend == '0)  state_d = ST_FIRE;
          else                      state_d = ST_LOAD;
        end
      end
      ST_CLEAR: begin
        if (clr_last) state_d = pend_any ? ST_LOAD : ST_FIRE;
      end
      ST_LOAD: begin
        if (!pend_any) state_d = ST_FIRE;
      end
      ST_FIRE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_en = hdr_acc | word_acc;
    pend_d  = hdr_acc ? hdr_pend : pend_rest;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) wr_en_q <= 1'b0;
    else            wr_en_q <= word_acc;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else if (word_acc) begin
      wr_idx_q  <= pend_idx;
      wr_data_q <= s_data;
    end
  end

  // ---------------- outputs ----------------
  assign wr_en    = wr_en_q;
  assign wr_idx   = wr_idx_q;
  assign wr_data  = wr_data_q;
  assign clr_busy = (state_q == ST_CLEAR);
  assign start    = (state_q == ST_FIRE);
  assign link_vld = start & link_seen;
  assign link_go  = link_vld & link_en_bit;
endmodule

// File: rtl/cl_loader_chk.sv
module cl_loader_chk
  import cl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              s_ready,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              clr_busy,
  input logic              start,
  input logic              link_vld,
  input logic              link_go
);
  assert_idx_assigned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> LOAD_MASK[wr_idx]);

  assert_ready_low_in_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> !s_ready);

  assert_no_write_in_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> !wr_en);

  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  assert_no_write_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !wr_en);

  assert_link_with_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_vld |-> start);

  assert_go_with_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_go |-> link_vld);

  assert_ready_low_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !s_ready);

  assert_ascending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_idx > $past(wr_idx)));
endmodule

bind cl_loader cl_loader_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_ready  (s_ready),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .clr_busy (clr_busy),
  .start    (start),
  .link_vld (link_vld),
  .link_go  (link_go)
);

// File: tb/tb_cl_loader.sv
module tb_cl_loader;
  localparam int CLK_PERIOD = 10;
  localparam int CLR_CYC    = 3;

  logic        clk, rst_n;
  logic        s_valid, s_ready;
  logic [31:0] s_data;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic        clr_busy, start, link_vld, link_go;
  logic [63:0] link_addr;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  cl_loader #(.CLR_CYC(CLR_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .clr_busy(clr_busy),
    .start(start), .link_vld(link_vld), .link_go(link_go), .link_addr(link_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit owns_word(input int b);
    return (b >= 2 && b <= 12) || b == 14 || b == 19 || b == 20 || b >= 29;
  endfunction

  function automatic logic [31:0] wd(input logic [31:0] hdr, input int k);
    return hdr ^ (32'h9E37_79B9 * 32'(k + 1)) ^ {8'(k), 24'h5A_0C33};
  endfunction

  task automatic run_cmd(input logic [31:0] hdr, input int seed);
    int idxs[32];
    int n = 0;
    logic [31:0] lo = '0;
    logic [31:0] hi = '0;
    bit lo_seen = 0;
    logic [63:0] exp_addr;
    for (int b = 0; b < 32; b++) if (hdr[b] && owns_word(b)) begin idxs[n] = b; n++; end

    chk(s_ready === 1'b1, "R8 ready for header", 64'(s_ready), 1);
    s_valid = 1'b1; s_data = hdr;
    @(posedge clk); @(negedge clk);

    if (hdr[0]) begin
      s_valid = (n > 0); s_data = wd(hdr, 0);
      for (int c = 0; c < CLR_CYC; c++) begin
        chk(clr_busy === 1'b1, "R4 clear active", 64'(clr_busy), 1);
        chk(s_ready === 1'b0, "R4 ready low in clear", 64'(s_ready), 0);
        chk(wr_en === 1'b0, "R4 no write in clear", 64'(wr_en), 0);
        @(posedge clk); @(negedge clk);
      end
      chk(clr_busy === 1'b0, "R4 clear length", 64'(clr_busy), 0);
    end else if (n == 0) begin
      s_valid = 1'b0;
    end

    if (n == 0) begin
      chk(start === 1'b1, "R6 immediate start", 64'(start), 1);
      chk(link_vld === 1'b0, "R7 no link", 64'(link_vld), 0);
      @(posedge clk); @(negedge clk);
      chk(start === 1'b0, "R5 start one cycle", 64'(start), 0);
      return;
    end

    for (int k = 0; k < n; k++) begin
      if (((k + seed) % 3) == 2) begin
        s_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(wr_en === 1'b0, "R9 no write on gap", 64'(wr_en), 0);
      end
      s_valid = 1'b1; s_data = wd(hdr, k);
      @(posedge clk); @(negedge clk);
      chk(wr_en === 1'b1, "R2 strobe", 64'(wr_en), 1);
      chk(wr_idx === 5'(idxs[k]), "R3 R10 index order", 64'(wr_idx), 64'(idxs[k]));
      chk(wr_data === wd(hdr, k), "R2 data", 64'(wr_data), 64'(wd(hdr, k)));
      chk(start === 1'b0, "R5 no start mid list", 64'(start), 0);
      if (idxs[k] == 30) begin lo = wd(hdr, k); lo_seen = 1; end
      if (idxs[k] == 31) hi = wd(hdr, k);
    end
    s_valid = 1'b0;
    chk(s_ready === 1'b0, "R8 ready low after list", 64'(s_ready), 0);
    @(posedge clk); @(negedge clk);
    chk(start === 1'b1, "R5 start after last write", 64'(start), 1);
    chk(wr_en === 1'b0, "R5 no write at start", 64'(wr_en), 0);
    chk(link_vld === lo_seen, "R7 link valid", 64'(link_vld), 64'(lo_seen));
    if (lo_seen) begin
      exp_addr = {hi, lo[31:1], 1'b0};
      chk(link_addr === exp_addr, "R7 link address", link_addr, exp_addr);
      chk(link_go === lo[0], "R7 link enable", 64'(link_go), 64'(lo[0]));
    end
    @(posedge clk); @(negedge clk);
    chk(start === 1'b0, "R5 start one cycle", 64'(start), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] x;
    rst_n = 1'b0; s_valid = 1'b0; s_data = '0;
    repeat (3) @(negedge clk);
    chk(wr_en === 1'b0, "R1 reset wr_en", 64'(wr_en), 0);
    chk(start === 1'b0, "R1 reset start", 64'(start), 0);
    chk(clr_busy === 1'b0, "R1 reset clear", 64'(clr_busy), 0);
    chk(link_vld === 1'b0, "R1 reset link", 64'(link_vld), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(s_ready === 1'b1, "R1 idle ready", 64'(s_ready), 1);
    chk(start === 1'b0, "R1 idle start", 64'(start), 0);

    for (int b = 0; b < 32; b++) run_cmd(32'h1 << b, b);
    run_cmd(32'hFFFF_FFFF, 0);
    run_cmd(32'hE018_5FFC, 1);
    run_cmd(32'h1FE7_A002, 2);
    run_cmd(32'h4000_0001, 0);
    run_cmd(32'hC000_0000, 1);
    run_cmd(32'h8000_0000, 2);

    x = 32'h1234_5679;
    for (int i = 0; i < 300; i++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      run_cmd(x, i);
    end
    finish_run();
  end
endmodule